// File: doc/BRIEF.md
# SPI Mode-0 Byte Exchange Sequencer

This block runs one full-duplex byte exchange on an SPI link with the clock idling low, data launched on falling edges and sampled on rising edges. A write strobe with a data byte loads the transmit shift register and starts a transfer. The transfer is stepped by a one-cycle `tick` clock-enable, which is typically the output of a rate divider elsewhere on the chip. The block drives the serial clock itself from a half-period state counter. Each tick advances the counter by one half period, so the serial clock runs at half the tick rate.

The most significant bit of the written byte appears on `mosi` as soon as the write is taken. The first rising serial-clock edge comes only after one full half period, so the first bit is settled before the peripheral samples it. Bits received on `miso` collect in an internal shift register. After the sixteenth half period the sequencer does three things together: it copies the received byte into a separate holding register, it pulses `done` for one system-clock cycle, and it drops `busy`. Chip-select decoding and the register map belong to the surrounding logic.

Top module: `spi_xfer_seq`

## Requirements
- R1: A synchronous active-low reset forces `sclk` low, `busy` low and `done` low, and it aborts a transfer in progress. A later write then starts a clean transfer.
- R2: A write strobe while idle starts a transfer. From the next cycle `busy` is high and `mosi` carries bit DATA_W-1 of the written byte, while `sclk` stays low until the first tick.
- R3: `sclk` changes state only in the cycle after a tick, and each tick during a transfer toggles it. One serial-clock period therefore takes two ticks, and `sclk` is low whenever the block is idle.
- R4: `mosi` shifts out the byte most significant bit first. It changes only when `sclk` falls, or when a new byte is loaded.
- R5: `miso` is sampled only at the ticks that raise `sclk`. The first sample lands in bit DATA_W-1 of the received byte and the last in bit 0. Its value at any other time has no effect.
- R6: The tick that ends the sixteenth half period ends the transfer. In the next cycle `done` is high for exactly one cycle, `busy` is low and `sclk` is low.
- R7: `rx_byte` takes the received byte in the same cycle that `done` is high, and it holds its value at all other times, including during the next transfer.
- R8: A write strobe while `busy` is high is ignored. The running transfer keeps its transmit bits and its length.
- R9: Ticks while idle have no effect on `sclk`, `busy`, `done` or `rx_byte`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Half-period step enable from the rate divider |
| wr_stb | input | 1 | Data byte write strobe; starts a transfer when idle |
| wr_data | input | DATA_W | Byte to transmit |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral, MSB first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| rx_byte | output | DATA_W | Holding register with the last received byte |

## Verification
The bench builds the block with its default DATA_W of 8. At this width every one of the 256 transmit bytes can be sent, each paired with a different peripheral reply computed arithmetically. The first sweep ticks every cycle. A second sweep uses a tick every third cycle and checks the quiet cycles between ticks; during that sweep the bench injects writes while busy and drives false `miso` levels during the falling half periods. Separate cases cover ticks while idle and a reset in the middle of a transfer.

// File: rtl/spi_seq_pkg.sv
// Package: shared types for the SPI mode-0 sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_seq_pkg;

    // Which serial-clock edge a tick produces in the current cycle.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } sclk_edge_e;

    // Width of a counter that must hold 0..2*bits without ambiguity.
    function automatic int half_ctr_width(input int bits);
        return $clog2(2 * bits) + 1;
    endfunction

endpackage

// File: rtl/spi_half_ctr.sv
// Module: half-period state counter. It keeps the running flag and counts
// 2*DATA_W half periods, one per tick. It derives sclk and reports which edge
// each tick produces.
// Assumes: start is asserted only while idle; tick is a one-cycle enable.
module spi_half_ctr
    import spi_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tick,
    output logic       running,
    output logic       sclk,
    output logic       last,
    output sclk_edge_e edge_kind
);
    localparam int HALVES = 2 * DATA_W;
    localparam int CW     = half_ctr_width(DATA_W);

    logic [CW-1:0] half_q;
    logic [CW-1:0] half_nxt;

    // Next half-period index; reaching HALVES is the rollover that ends the transfer.
    assign half_nxt = half_q + 1'b1;

    // Running flag and half-period index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            half_q  <= '0;
        end else if (start) begin
            running <= 1'b1;
            half_q  <= '0;
        end else if (running && tick) begin
            if (half_nxt == CW'(HALVES)) begin
                running <= 1'b0;
                half_q  <= '0;
            end else begin
                half_q <= half_nxt;
            end
        end
    end

    // Serial clock: high in odd half periods, low in even ones and while idle.
    assign sclk = running & half_q[0];

    // Final tick of the transfer.
    assign last = running && tick && (half_nxt == CW'(HALVES));

    // Edge classification for the shift logic.
    always_comb begin
        edge_kind = EDGE_NONE;
        if (running && tick) begin
            edge_kind = half_q[0] ? EDGE_FALL : EDGE_RISE;
        end
    end

    // sclk may only move in the cycle after a tick (R3).
    assert_sclk_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick)) |-> $stable(sclk));

    // The clock is low whenever the block is idle (R3).
    assert_sclk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !sclk);

endmodule

// File: rtl/spi_shift_pair.sv
// Module: transmit and receive shift registers. The transmit register loads
// on start and shifts left on falling edges; mosi is its MSB. The receive
// register shifts miso in on rising edges.
// Assumes: edge_kind comes from spi_half_ctr; load and an edge never coincide.
module spi_shift_pair
    import spi_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  sclk_edge_e        edge_kind,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_shift
);
    logic [DATA_W-1:0] tx_q;

    // Transmit register: parallel load, then shift toward the MSB on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
        end else if (edge_kind == EDGE_FALL) begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    // Receive register: the first sample ends up in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_shift <= '0;
        end else if (edge_kind == EDGE_RISE) begin
            rx_shift <= {rx_shift[DATA_W-2:0], miso};
        end
    end

    assign mosi = tx_q[DATA_W-1];

endmodule

// File: rtl/spi_rx_hold.sv
// Module: holding register for the received byte and the completion pulse.
// Both update on the final tick.
// Assumes: capture is a one-cycle pulse; the holding register needs no reset.
module spi_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] rx_in,
    output logic [DATA_W-1:0] hold_q,
    output logic              done
);
    // Holding register, written only at the end of a transfer.
    always_ff @(posedge clk) begin
        if (capture) begin
            hold_q <= rx_in;
        end
    end

    // Completion pulse, registered alongside the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= capture;
        end
    end

endmodule

// File: rtl/spi_xfer_seq.sv
// Module: top of the SPI mode-0 byte exchange sequencer. A write while idle
// starts a transfer; ticks step it through 2*DATA_W half periods; the end of
// the transfer loads rx_byte and pulses done.
// Assumes: tick is a one-cycle enable at twice the wanted serial-clock rate.
module spi_xfer_seq
    import spi_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    logic              running;
    logic              last;
    logic              start;
    sclk_edge_e        edge_kind;
    logic [DATA_W-1:0] rx_shift;

    // A write is accepted only while idle.
    assign start = wr_stb & ~running;
    assign busy  = running;

    spi_half_ctr #(.DATA_W(DATA_W)) ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tick      (tick),
        .running   (running),
        .sclk      (sclk),
        .last      (last),
        .edge_kind (edge_kind)
    );

    spi_shift_pair #(.DATA_W(DATA_W)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_data (wr_data),
        .edge_kind (edge_kind),
        .miso      (miso),
        .mosi      (mosi),
        .rx_shift  (rx_shift)
    );

    spi_rx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (last),
        .rx_in   (rx_shift),
        .hold_q  (rx_byte),
        .done    (done)
    );

    // mosi moves only on a falling sclk or right after a load (R4).
    assert_mosi_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(start) && !$fell(sclk)) |-> $stable(mosi));

    // done is a single-cycle pulse with busy already low and sclk low (R6).
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !sclk) ##1 !done);

    // busy drops only at the end of a transfer, never silently (R6).
    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(busy)) |-> done);

    // rx_byte changes only together with done (R7).
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !done) |-> $stable(rx_byte));

    // A write while busy leaves the transfer running (R8).
    assert_busy_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb && !last) |=> busy);

endmodule

// File: tb/spi_xfer_seq_tb_top.sv
// Bench: sweeps every transmit byte with an arithmetic peripheral reply and
// checks the serial waveform, completion and holding register at the ports.
module spi_xfer_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_stb = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         miso = 1'b0;
    logic         sclk, mosi, busy, done;
    logic [W-1:0] rx_byte;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    bit  have_prev = 1'b0;
    logic [W-1:0] prev_rx = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_xfer_seq #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_stb(wr_stb),
        .wr_data(wr_data), .miso(miso), .sclk(sclk), .mosi(mosi),
        .busy(busy), .done(done), .rx_byte(rx_byte)
    );

    // Records one check; reports a failure with actual and expected values.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] reply_of(input logic [W-1:0] tx);
        return W'((int'(tx) * 37 + 11) % 256);
    endfunction

    // Runs one transfer; p = cycles between ticks, inject = write while busy.
    task automatic run_xfer(input logic [W-1:0] tx, input int p, input bit inject);
        logic [W-1:0] sl;
        sl = reply_of(tx);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = tx;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(busy == 1'b1, "R2 busy after write", busy, 1);
        for (int h = 0; h < 2*W; h++) begin
            chk(sclk == h[0], "R3 sclk level", sclk, h[0]);
            if (h[0] == 1'b0) begin
                chk(mosi == tx[W-1-h/2], "R4 mosi bit", mosi, tx[W-1-h/2]);
                miso = sl[W-1-h/2];
            end else begin
                miso = ~sl[W-1-(h-1)/2];   // R5 noise away from rising edges
            end
            if (have_prev) chk(rx_byte == prev_rx, "R7 hold stable", rx_byte, prev_rx);
            tick = 1'b1;
            if (inject && h == 5) begin
                wr_stb = 1'b1; wr_data = ~tx;   // R8 write while busy
            end
            @(negedge clk);
            tick = 1'b0; wr_stb = 1'b0;
            if (h == 2*W-1) begin
                chk(done == 1'b1, "R6 done pulse", done, 1);
                chk(busy == 1'b0, "R6 busy low", busy, 0);
                chk(sclk == 1'b0, "R6 sclk low", sclk, 0);
                chk(rx_byte == sl, "R5 R7 received byte", rx_byte, sl);
                @(negedge clk);
                chk(done == 1'b0, "R6 done one cycle", done, 0);
                chk(rx_byte == sl, "R7 hold after done", rx_byte, sl);
            end else begin
                for (int k = 1; k < p; k++) begin
                    chk(sclk == ~h[0], "R3 sclk holds between ticks", sclk, ~h[0]);
                    chk(busy == 1'b1, "R8 busy holds", busy, 1);
                    @(negedge clk);
                end
            end
        end
        prev_rx = sl;
        have_prev = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset in the middle of a transfer
        wr_stb = 1'b1; wr_data = 8'hA5;
        @(negedge clk);
        wr_stb = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0;
        end
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R1 abort sclk", sclk, 0);
        chk(busy == 1'b0, "R1 abort busy", busy, 0);
        chk(done == 1'b0, "R1 abort done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2..R7: every byte, tick every cycle
        for (int v = 0; v < 256; v++) run_xfer(W'(v), 1, 1'b0);

        // R9: ticks while idle
        for (int i = 0; i < 6; i++) begin
            tick = 1'b1; miso = i[0];
            @(negedge clk);
            tick = 1'b0;
            chk(sclk == 1'b0, "R9 idle sclk", sclk, 0);
            chk(busy == 1'b0, "R9 idle busy", busy, 0);
            chk(done == 1'b0, "R9 idle done", done, 0);
            chk(rx_byte == prev_rx, "R9 idle hold", rx_byte, prev_rx);
        end

        // R3, R8: slower tick, writes injected while busy
        for (int v = 0; v < 32; v++) run_xfer(W'(v * 8 + 3), 3, v[0]);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule